// File: doc/BRIEF.md
# Board Command Mailbox Registers

This block is a small register window that lets software send one command word to a board controller. It holds three 32-bit registers: a data word, a command word and a two-bit status word. Writing the command word decodes it in the same cycle against two fixed command codes. A recognised code raises a one-cycle power-off or restart pulse toward the system reset logic. Every command write reports completion in the status word. An unrecognised code also sets an error flag there.

The window exists only when the board variant input carries the identifier 0x190. For any other variant its three offsets read as zero and writes to them have no effect. The registered state is kept, so it shows up again when the variant input returns to 0x190. The bus side is a plain 32-bit read/write port with a combinational read path. No serial link to the controller is modelled, because every command completes at once.

Top module: `cfg_cmd_regs`

## Requirements
- R1: After reset all three registers read zero, and both request pulses are low.
- R2: Offset 0xA0 is the data register. A write stores all 32 bits, and a read returns them.
- R3: A write to offset 0xA4 (command register) stores the written value with bits 19 and 18 cleared. The start bit (bit 31) is then also cleared before storage.
- R4: Every command write sets the status register (offset 0xA8) bit 0, meaning done, in the cycle after the write.
- R5: If the command value with bits 19:18 cleared equals 0xC0800000, `pwroff_req` is high for exactly the one cycle after the write, and status reads 1.
- R6: If the command value with bits 19:18 cleared equals 0xC0900000, `restart_req` is high for exactly the one cycle after the write, and status reads 1.
- R7: Any other command value sets status to 3 (bit 1 = error, bit 0 = done) and raises no pulse.
- R8: A write to the status register stores only data bits 1:0. Reads of status return zero in bits 31:2.
- R9: When `variant_id` is not 0x190, the three offsets read zero, writes to them change no register, and no pulse is raised.
- R10: Any offset other than 0xA0, 0xA4 and 0xA8, and any cycle with `rd_en` low, gives `rdata` of zero. Writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| variant_id | input | 12 | Board variant identifier; the window is present only at 0x190 |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte offset within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, zero when not reading a live register |
| pwroff_req | output | 1 | One-cycle power-off request |
| restart_req | output | 1 | One-cycle restart request |

## Verification
The stimulus includes command words that differ from a code only in bits 19:18. A design that compared before masking would miss those commands and report an error instead. Back-to-back command writes check that each pulse stays one cycle wide and that the status is rewritten on each write, not sticky-ORed. Writes made while the variant input is foreign are followed by reads after the variant returns to 0x190. A design that gated only its read path would show the foreign data there. Status writes with ones in the upper bits check that the stored value is truncated to two bits.

// File: rtl/cfg_cmd_regs.sv
module cfg_cmd_regs #(
  parameter int              ADDR_W       = 12,
  parameter int              VAR_W        = 12,
  parameter logic [VAR_W-1:0] PRESENT_ID  = 12'h190,
  parameter logic [31:0]     PWROFF_CODE  = 32'hC080_0000,
  parameter logic [31:0]     RESTART_CODE = 32'hC090_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VAR_W-1:0]  variant_id,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              pwroff_req,
  output logic              restart_req
);

  localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(8'hA0);
  localparam logic [ADDR_W-1:0] OFF_CMD  = ADDR_W'(8'hA4);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(8'hA8);
  localparam logic [31:0] DROP_MASK  = 32'h000C_0000;
  localparam logic [31:0] START_MASK = 32'h8000_0000;

  logic [31:0] data_q, cmd_q;
  logic [1:0]  stat_q;
  logic        pwroff_q, restart_q;

  wire         live     = (variant_id == PRESENT_ID);
  wire         wr_data  = wr_en && live && (addr == OFF_DATA);
  wire         wr_cmd   = wr_en && live && (addr == OFF_CMD);
  wire         wr_stat  = wr_en && live && (addr == OFF_STAT);
  wire  [31:0] cmd_word = wdata & ~DROP_MASK;
  wire         hit_off  = (cmd_word == PWROFF_CODE);
  wire         hit_rst  = (cmd_word == RESTART_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q    <= '0;
      cmd_q     <= '0;
      stat_q    <= '0;
      pwroff_q  <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      pwroff_q  <= wr_cmd && hit_off;
      restart_q <= wr_cmd && hit_rst;
      if (wr_data) data_q <= wdata;
      if (wr_cmd) begin
        cmd_q  <= cmd_word & ~START_MASK;
        stat_q <= {~(hit_off || hit_rst), 1'b1};
      end else if (wr_stat) begin
        stat_q <= wdata[1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en && live) begin
      unique case (addr)
        OFF_DATA: rdata = data_q;
        OFF_CMD:  rdata = cmd_q;
        OFF_STAT: rdata = {30'd0, stat_q};
        default:  rdata = '0;
      endcase
    end
  end

  assign pwroff_req  = pwroff_q;
  assign restart_req = restart_q;

  a_r5_pwroff_cause: assert property (@(posedge clk) disable iff (!rst_n)
    pwroff_req |-> ($past(wr_en) && $past(addr) == OFF_CMD && $past(variant_id) == PRESENT_ID
                    && (($past(wdata) & ~DROP_MASK) == PWROFF_CODE)));

  a_r6_restart_cause: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |-> ($past(wr_en) && $past(addr) == OFF_CMD && $past(variant_id) == PRESENT_ID
                     && (($past(wdata) & ~DROP_MASK) == RESTART_CODE)));

  a_r7_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pwroff_req, restart_req}));

  a_r4_done_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && live && addr == OFF_CMD) |=> stat_q[0]);

  a_r3_cmd_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && live && addr == OFF_CMD) |=> (cmd_q[31] == 1'b0 && cmd_q[19:18] == 2'b00));

  a_r8_stat_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && live && addr == OFF_STAT) |=> (stat_q == $past(wdata[1:0])));

  a_r9_absent_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (variant_id != PRESENT_ID) |-> (rdata == 32'd0));

  a_r9_absent_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (variant_id != PRESENT_ID) |=> ($stable(data_q) && $stable(cmd_q) && $stable(stat_q)));

endmodule

// File: tb/test_cfg_cmd_regs.sv
module test_cfg_cmd_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] variant_id = 12'h190;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwroff_req, restart_req;

  int vecs = 0, bad = 0;
  bit done = 0;

  longint unsigned m_data, m_cmd, m_stat;
  bit m_off, m_rst;

  always #4 clk = ~clk;

  cfg_cmd_regs i_cfg_cmd_regs (
    .clk(clk), .rst_n(rst_n), .variant_id(variant_id), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pwroff_req(pwroff_req), .restart_req(restart_req)
  );

  function automatic logic [31:0] model_read(logic re, logic [11:0] a, logic [11:0] v);
    if (!re || v != 12'h190) return 32'd0;
    case (a)
      12'h0A0: return 32'(m_data);
      12'h0A4: return 32'(m_cmd);
      12'h0A8: return 32'(m_stat);
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag, logic we, logic re, logic [11:0] a, logic [31:0] d,
                      logic [11:0] v = 12'h190);
    logic [31:0] w;
    wr_en = we; rd_en = re; addr = a; wdata = d; variant_id = v;
    #1;
    check({tag, " rdata"}, rdata, model_read(re, a, v));
    check("R5 pwroff pulse", {31'd0, pwroff_req}, {31'd0, m_off});
    check("R6 restart pulse", {31'd0, restart_req}, {31'd0, m_rst});
    @(posedge clk);
    #1;
    m_off = 0; m_rst = 0;
    if (we && v == 12'h190) begin
      case (a)
        12'h0A0: m_data = d;
        12'h0A4: begin
          w = d & 32'hFFF3_FFFF;
          m_off = (w == 32'hC080_0000);
          m_rst = (w == 32'hC090_0000);
          m_stat = (m_off || m_rst) ? 1 : 3;
          m_cmd = w & 32'h7FFF_FFFF;
        end
        12'h0A8: m_stat = d & 3;
        default: ;
      endcase
    end
  endtask

  task automatic rd3(string tag, logic [11:0] v = 12'h190);
    step(tag, 0, 1, 12'h0A0, 0, v);
    step(tag, 0, 1, 12'h0A4, 0, v);
    step(tag, 0, 1, 12'h0A8, 0, v);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    m_data = 0; m_cmd = 0; m_stat = 0; m_off = 0; m_rst = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd3("R1 reset");
    step("R2 data wr", 1, 0, 12'h0A0, 32'hDEAD_BEEF);
    step("R2 data rd", 0, 1, 12'h0A0, 0);
    step("R5 off cmd", 1, 0, 12'h0A4, 32'hC080_0000);
    rd3("R5 after off");
    step("R5 masked off", 1, 0, 12'h0A4, 32'hC08C_0000);
    step("R3 cmd rd", 0, 1, 12'h0A4, 0);
    step("R6 restart", 1, 0, 12'h0A4, 32'hC094_0000);
    step("R4 stat rd", 0, 1, 12'h0A8, 0);
    step("R7 bad cmd", 1, 0, 12'h0A4, 32'h1234_5678);
    rd3("R7 after bad");
    step("R8 stat wr", 1, 0, 12'h0A8, 32'hFFFF_FFFE);
    step("R8 stat rd", 0, 1, 12'h0A8, 0);
    step("R8 stat clr", 1, 0, 12'h0A8, 32'h0000_0000);
    step("R7 b2b 1", 1, 1, 12'h0A4, 32'hC090_0000);
    step("R7 b2b 2", 1, 1, 12'h0A4, 32'hC080_0000);
    step("R7 b2b 3", 1, 1, 12'h0A4, 32'h8000_0001);
    rd3("R4 after b2b");
    step("R9 absent data", 1, 1, 12'h0A0, 32'h5555_AAAA, 12'h182);
    step("R9 absent cmd", 1, 1, 12'h0A4, 32'hC080_0000, 12'h182);
    step("R9 absent stat", 1, 1, 12'h0A8, 32'h0000_0000, 12'h182);
    rd3("R9 absent rd", 12'h100);
    rd3("R9 back");
    step("R10 odd offs", 1, 1, 12'h0A1, 32'hFFFF_FFFF);
    step("R10 zero offs", 1, 1, 12'h000, 32'hFFFF_FFFF);
    step("R10 past end", 1, 1, 12'h0AC, 32'hFFFF_FFFF);
    step("R10 no rd_en", 0, 0, 12'h0A0, 0);
    rd3("R10 after");
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      case ($urandom_range(0, 4))
        0: a = 12'h0A0; 1: a = 12'h0A4; 2: a = 12'h0A8; 3: a = 12'h0A4; default: a = 12'(($urandom_range(0, 63)) << 2);
      endcase
      case ($urandom_range(0, 3))
        0: d = 32'hC080_0000 | (32'($urandom_range(0, 3)) << 18);
        1: d = 32'hC090_0000 | (32'($urandom_range(0, 3)) << 18);
        default: d = $urandom;
      endcase
      step("R2 R7 random", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, d,
           ($urandom_range(0, 5) == 0) ? 12'h178 : 12'h190);
    end
    rd3("R1 final");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule